// File: doc/BRIEF.md
# Instruction Line Prefetch Request Queue

This block holds pending instruction line-fetch requests and decides when each one may use the shared local-store access port. Each slot stores a line address, which is the index of a 128-byte-aligned line. It also stores a destination code and a stale flag. Requests come from two sources. Inline requests are aimed at one of two sequential line buffers. Hint requests are aimed at the branch-target buffer and are always served before any inline request.

The oldest request sits at the head of the queue. It moves into a six-stage access pipe when two conditions hold: the front stage of the pipe is empty, and no load/store instruction is about to claim the port. When a request leaves the last pipe stage, the block reports its line address and destination for one cycle.

A trigger event marks every queued inline request as stale. A stale request is still served if it reaches the pipe first. A later purge event deletes all stale requests that remain, and the survivors keep their order. A request that finds no free slot is dropped, and this is reported on an overflow output.

Top module: `iprefetch_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_valid` and `overflow` are low, and the queue is empty.
- R2: Requests leave the queue oldest first. Each completion reports the request's line address on `done_line` and its destination on `done_dest`. The codes are 1 for the first inline buffer (`inl_req_sel`=0), 2 for the second inline buffer (`inl_req_sel`=1) and 3 for the hint buffer. Code 0 is never reported.
- R3: A request presented to an empty queue with the port free is reported on `done_valid` in the seventh cycle after the cycle in which it was presented.
- R4: Two requests never enter the access pipe in consecutive cycles.
- R5: With `cfg_loads_only`=1, no request enters the pipe in a cycle with `ldst_valid`=1 and `ldst_is_store`=0. In that mode a store (`ldst_is_store`=1) has no effect on entry.
- R6: With `cfg_loads_only`=0, no request enters the pipe in any cycle with `ldst_valid`=1.
- R7: A hint request is placed behind any hint requests already queued and ahead of every queued inline request.
- R8: When a hint request and an inline request arrive in the same cycle, the hint is placed first. If only one slot is free, the inline request is dropped.
- R9: `hint_trigger` marks every queued inline request stale. An inline request that arrives in the same cycle stays fresh, and hint requests are never marked. Stale requests that reach the pipe are served normally.
- R10: `purge_stale` deletes every stale request. The remaining requests close up and keep their relative order.
- R11: A request that arrives when no slot is free is dropped, and `overflow` is high for one cycle in the next cycle.
- R12: A stale request that enters the pipe in the same cycle as a purge is still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_loads_only | input | 1 | 1: only loads block the port; 0: loads and stores block it |
| inl_req_valid | input | 1 | Inline request present this cycle |
| inl_req_line | input | LINE_W | Line index of the inline request |
| inl_req_sel | input | 1 | Inline target: 0 first buffer, 1 second buffer |
| hint_req_valid | input | 1 | Hint-buffer request present this cycle |
| hint_req_line | input | LINE_W | Line index of the hint request |
| hint_trigger | input | 1 | Marks queued inline requests stale |
| purge_stale | input | 1 | Deletes stale requests |
| ldst_valid | input | 1 | A load/store sits in the stage before the port |
| ldst_is_store | input | 1 | That instruction is a store |
| done_valid | output | 1 | A request leaves the last pipe stage |
| done_line | output | LINE_W | Line index of the completed request |
| done_dest | output | 2 | Destination code of the completed request |
| overflow | output | 1 | A request was dropped in the previous cycle |

## Verification
The hardest collisions are a purge that lands in the same cycle as a head request entering the pipe, and a hint insertion that coincides with an inline arrival when only one slot is free. Both are provoked on purpose. A load/store stream holds the queue at a chosen fill level, and then the port is released or both requests are driven in the same cycle as the event. The outcome is judged from the order and membership of the reported completions and from the overflow pulse. A bench model built from the requirements predicts both, cycle by cycle. Random phases in both conflict modes then mix triggers, purges and bursts so that these coincidences also occur without being planned.

// File: rtl/iprefetch_pkg.sv
package iprefetch_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_INL1 = 2'd1,
    DST_INL2 = 2'd2,
    DST_HINT = 2'd3
  } dest_t;

  typedef struct packed {
    logic  valid;
    logic  stale;
    dest_t dest;
  } slot_t;

endpackage

// File: rtl/iprefetch_slots.sv
module iprefetch_slots
  import iprefetch_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              trig_i,
  input  logic              purge_i,
  input  logic              inl_v_i,
  input  logic [LINE_W-1:0] inl_line_i,
  input  dest_t             inl_dest_i,
  input  logic              hint_v_i,
  input  logic [LINE_W-1:0] hint_line_i,
  output logic              head_v_o,
  output logic [LINE_W-1:0] head_line_o,
  output dest_t             head_dest_o,
  output logic [DEPTH-1:0]  stale_o,
  output logic              ovf_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  slot_t             fq_q [DEPTH];
  slot_t             fq_d [DEPTH];
  logic [LINE_W-1:0] la_q [DEPTH];
  logic [LINE_W-1:0] la_d [DEPTH];
  logic              ovf_d;

  slot_t             f0 [DEPTH];
  slot_t             f1 [DEPTH];
  logic [LINE_W-1:0] a0 [DEPTH];
  logic [LINE_W-1:0] a1 [DEPTH];
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     nh;

  // Next state: pop, purge with compaction, stale marking, then insertion.
  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      f0[i] = pop_i ? fq_q[i+1] : fq_q[i];
      a0[i] = pop_i ? la_q[i+1] : la_q[i];
    end
    f0[DEPTH-1] = pop_i ? slot_t'('0) : fq_q[DEPTH-1];
    a0[DEPTH-1] = pop_i ? '0 : la_q[DEPTH-1];

    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      f1[i] = '0;
      a1[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (f0[i].valid && !(purge_i && f0[i].stale)) begin
        f1[cnt[IW-1:0]] = f0[i];
        a1[cnt[IW-1:0]] = a0[i];
        cnt = cnt + 1'b1;
      end
    end

    nh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (trig_i && f1[i].valid && f1[i].dest != DST_HINT) f1[i].stale = 1'b1;
      if (f1[i].valid && f1[i].dest == DST_HINT) nh = nh + 1'b1;
    end

    ovf_d = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      fq_d[i] = f1[i];
      la_d[i] = a1[i];
    end
    if (hint_v_i) begin
      if (cnt < CW'(DEPTH)) begin
        for (int i = DEPTH - 1; i > 0; i--) begin
          if (i > int'(nh)) begin
            fq_d[i] = f1[i-1];
            la_d[i] = a1[i-1];
          end
        end
        fq_d[nh[IW-1:0]] = '{valid: 1'b1, stale: 1'b0, dest: DST_HINT};
        la_d[nh[IW-1:0]] = hint_line_i;
        cnt = cnt + 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
    if (inl_v_i) begin
      if (cnt < CW'(DEPTH)) begin
        fq_d[cnt[IW-1:0]] = '{valid: 1'b1, stale: 1'b0, dest: inl_dest_i};
        la_d[cnt[IW-1:0]] = inl_line_i;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        fq_q[i] <= '0;
        la_q[i] <= '0;
      end
      ovf_o <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        fq_q[i] <= fq_d[i];
        la_q[i] <= la_d[i];
      end
      ovf_o <= ovf_d;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) stale_o[i] = fq_q[i].valid && fq_q[i].stale;
  end

  assign head_v_o    = fq_q[0].valid;
  assign head_line_o = la_q[0];
  assign head_dest_o = fq_q[0].dest;

endmodule

// File: rtl/iprefetch_gate.sv
module iprefetch_gate (
  input  logic head_v_i,
  input  logic front_busy_i,
  input  logic ldst_v_i,
  input  logic ldst_store_i,
  input  logic loads_only_i,
  output logic pop_o
);

  logic port_taken;

  // A load always wins the port; a store wins it only when both kinds contend.
  assign port_taken = ldst_v_i && (!loads_only_i || !ldst_store_i);
  assign pop_o      = head_v_i && !front_busy_i && !port_taken;

endmodule

// File: rtl/iprefetch_pipe.sv
module iprefetch_pipe
  import iprefetch_pkg::*;
#(
  parameter int STAGES = 6,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v_i,
  input  logic [LINE_W-1:0] in_line_i,
  input  dest_t             in_dest_i,
  output logic              front_busy_o,
  output logic              out_v_o,
  output logic [LINE_W-1:0] out_line_o,
  output dest_t             out_dest_o
);

  logic [STAGES-1:0] v_q;
  logic [STAGES-1:0] v_d;
  logic [LINE_W-1:0] l_q [STAGES];
  dest_t             d_q [STAGES];

  assign v_d = {v_q[STAGES-2:0], in_v_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  // Payload registers: no reset, loaded only when a request moves in.
  always_ff @(posedge clk) begin
    if (in_v_i) begin
      l_q[0] <= in_line_i;
      d_q[0] <= in_dest_i;
    end
    for (int s = 1; s < STAGES; s++) begin
      if (v_q[s-1]) begin
        l_q[s] <= l_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign front_busy_o = v_q[0];
  assign out_v_o      = v_q[STAGES-1];
  assign out_line_o   = l_q[STAGES-1];
  assign out_dest_o   = d_q[STAGES-1];

endmodule

// File: rtl/iprefetch_queue.sv
module iprefetch_queue
  import iprefetch_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int STAGES = 6,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_loads_only,
  input  logic              inl_req_valid,
  input  logic [LINE_W-1:0] inl_req_line,
  input  logic              inl_req_sel,
  input  logic              hint_req_valid,
  input  logic [LINE_W-1:0] hint_req_line,
  input  logic              hint_trigger,
  input  logic              purge_stale,
  input  logic              ldst_valid,
  input  logic              ldst_is_store,
  output logic              done_valid,
  output logic [LINE_W-1:0] done_line,
  output logic [1:0]        done_dest,
  output logic              overflow
);

  logic              pop;
  logic              head_v;
  logic [LINE_W-1:0] head_line;
  dest_t             head_dest;
  logic              front_busy;
  logic [DEPTH-1:0]  stale_vec;
  dest_t             inl_dest;
  dest_t             out_dest;

  assign inl_dest = inl_req_sel ? DST_INL2 : DST_INL1;

  iprefetch_slots #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_i       (pop),
    .trig_i      (hint_trigger),
    .purge_i     (purge_stale),
    .inl_v_i     (inl_req_valid),
    .inl_line_i  (inl_req_line),
    .inl_dest_i  (inl_dest),
    .hint_v_i    (hint_req_valid),
    .hint_line_i (hint_req_line),
    .head_v_o    (head_v),
    .head_line_o (head_line),
    .head_dest_o (head_dest),
    .stale_o     (stale_vec),
    .ovf_o       (overflow)
  );

  iprefetch_gate u_gate (
    .head_v_i     (head_v),
    .front_busy_i (front_busy),
    .ldst_v_i     (ldst_valid),
    .ldst_store_i (ldst_is_store),
    .loads_only_i (cfg_loads_only),
    .pop_o        (pop)
  );

  iprefetch_pipe #(.STAGES(STAGES), .LINE_W(LINE_W)) u_pipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_v_i       (pop),
    .in_line_i    (head_line),
    .in_dest_i    (head_dest),
    .front_busy_o (front_busy),
    .out_v_o      (done_valid),
    .out_line_o   (done_line),
    .out_dest_o   (out_dest)
  );

  assign done_dest = out_dest;

endmodule

// File: rtl/iprefetch_queue_chk.sv
module iprefetch_queue_chk #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pop,
  input logic             cfg_loads_only,
  input logic             ldst_valid,
  input logic             ldst_is_store,
  input logic             inl_req_valid,
  input logic             hint_req_valid,
  input logic             hint_trigger,
  input logic             purge_stale,
  input logic [DEPTH-1:0] stale_vec,
  input logic             done_valid,
  input logic [1:0]       done_dest,
  input logic             overflow
);

  // R4
  pop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop);

  // R5
  load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldst_valid && !ldst_is_store) |-> !pop);

  // R6
  store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldst_valid && !cfg_loads_only) |-> !pop);

  // R10
  purge_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_stale && !hint_trigger) |=> (stale_vec == '0));

  // R11
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(inl_req_valid || hint_req_valid));

  // R2
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_dest != 2'd0));

endmodule

bind iprefetch_queue iprefetch_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pop            (pop),
  .cfg_loads_only (cfg_loads_only),
  .ldst_valid     (ldst_valid),
  .ldst_is_store  (ldst_is_store),
  .inl_req_valid  (inl_req_valid),
  .hint_req_valid (hint_req_valid),
  .hint_trigger   (hint_trigger),
  .purge_stale    (purge_stale),
  .stale_vec      (stale_vec),
  .done_valid     (done_valid),
  .done_dest      (done_dest),
  .overflow       (overflow)
);

// File: tb/test_iprefetch_queue.sv
`timescale 1ns/1ps
module test_iprefetch_queue;

  localparam int LW = 11;
  localparam int QD = 4;
  localparam int PS = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_l, iv, isel, hv, trg, prg, lv, ls;
  logic [LW-1:0] il, hl;
  logic done_valid, overflow;
  logic [LW-1:0] done_line;
  logic [1:0] done_dest;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [LW-1:0] mq_l [QD];
  logic [1:0]    mq_d [QD];
  logic          mq_s [QD];
  int            mcnt;
  logic          mp_v [PS];
  logic [LW-1:0] mp_l [PS];
  logic [1:0]    mp_d [PS];
  logic          m_ovf;

  always #5 clk = ~clk;

  iprefetch_queue i_iprefetch_queue (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_loads_only (cfg_l),
    .inl_req_valid  (iv),
    .inl_req_line   (il),
    .inl_req_sel    (isel),
    .hint_req_valid (hv),
    .hint_req_line  (hl),
    .hint_trigger   (trg),
    .purge_stale    (prg),
    .ldst_valid     (lv),
    .ldst_is_store  (ls),
    .done_valid     (done_valid),
    .done_line      (done_line),
    .done_dest      (done_dest),
    .overflow       (overflow)
  );

  function automatic logic [1:0] inl_code(input logic sel);
    return sel ? 2'd2 : 2'd1;
  endfunction

  task automatic model_reset();
    mcnt = 0;
    m_ovf = 1'b0;
    for (int i = 0; i < QD; i++) begin
      mq_l[i] = '0; mq_d[i] = '0; mq_s[i] = 1'b0;
    end
    for (int s = 0; s < PS; s++) begin
      mp_v[s] = 1'b0; mp_l[s] = '0; mp_d[s] = '0;
    end
  endtask

  task automatic model_step();
    logic go;
    logic drop;
    int k;
    int nh;
    go = (mcnt > 0) && !mp_v[0] && !(lv && (!cfg_l || !ls));
    for (int s = PS - 1; s > 0; s--) begin
      mp_v[s] = mp_v[s-1]; mp_l[s] = mp_l[s-1]; mp_d[s] = mp_d[s-1];
    end
    mp_v[0] = go; mp_l[0] = mq_l[0]; mp_d[0] = mq_d[0];
    if (go) begin
      for (int i = 0; i < QD - 1; i++) begin
        mq_l[i] = mq_l[i+1]; mq_d[i] = mq_d[i+1]; mq_s[i] = mq_s[i+1];
      end
      mcnt--;
    end
    if (prg) begin
      k = 0;
      for (int i = 0; i < mcnt; i++) begin
        if (!mq_s[i]) begin
          mq_l[k] = mq_l[i]; mq_d[k] = mq_d[i]; mq_s[k] = 1'b0; k++;
        end
      end
      mcnt = k;
    end
    if (trg) begin
      for (int i = 0; i < mcnt; i++) if (mq_d[i] != 2'd3) mq_s[i] = 1'b1;
    end
    drop = 1'b0;
    if (hv) begin
      if (mcnt < QD) begin
        nh = 0;
        for (int i = 0; i < mcnt; i++) if (mq_d[i] == 2'd3) nh++;
        for (int i = mcnt; i > nh; i--) begin
          mq_l[i] = mq_l[i-1]; mq_d[i] = mq_d[i-1]; mq_s[i] = mq_s[i-1];
        end
        mq_l[nh] = hl; mq_d[nh] = 2'd3; mq_s[nh] = 1'b0;
        mcnt++;
      end else drop = 1'b1;
    end
    if (iv) begin
      if (mcnt < QD) begin
        mq_l[mcnt] = il; mq_d[mcnt] = inl_code(isel); mq_s[mcnt] = 1'b0;
        mcnt++;
      end else drop = 1'b1;
    end
    m_ovf = drop;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (done_valid !== mp_v[PS-1] || overflow !== m_ovf ||
        (mp_v[PS-1] && (done_line !== mp_l[PS-1] || done_dest !== mp_d[PS-1]))) begin
      errors++;
      $display("FAIL %s: got v=%0b line=%0h dest=%0d ovf=%0b, expected v=%0b line=%0h dest=%0d ovf=%0b",
               tag, done_valid, done_line, done_dest, overflow,
               mp_v[PS-1], mp_l[PS-1], mp_d[PS-1], m_ovf);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    iv = 0; hv = 0; trg = 0; prg = 0;
  endtask

  task automatic drain(input string tag);
    quiet(); lv = 0;
    for (int c = 0; c < 14; c++) tick(tag);
  endtask

  task automatic push_inl(input logic [LW-1:0] a, input logic sel, input string tag);
    iv = 1; il = a; isel = sel; tick(tag); iv = 0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(1_990_000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    int lat;
    rst_n = 0; cfg_l = 1; iv = 0; isel = 0; hv = 0; trg = 0; prg = 0; lv = 0; ls = 0;
    il = '0; hl = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (done_valid !== 1'b0 || overflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0b ovf=%0b, expected 0 0", done_valid, overflow);
    end
    rst_n = 1;
    tick("R1");

    // R3: latency count on an empty queue
    iv = 1; il = 11'h0A5; isel = 0; tick("R3"); iv = 0;
    lat = 1;
    while (!done_valid && lat < 20) begin tick("R3"); lat++; end
    checks++;
    if (lat != 7 || done_line !== 11'h0A5 || done_dest !== 2'd1) begin
      errors++;
      $display("FAIL R3: got latency=%0d line=%0h dest=%0d, expected 7 a5 1", lat, done_line, done_dest);
    end
    drain("R3");

    // R4: back-to-back arrivals are served no faster than every other cycle
    push_inl(11'h010, 0, "R4"); push_inl(11'h011, 1, "R4"); push_inl(11'h012, 0, "R4");
    drain("R4");

    // R5: loads block, stores ignored in loads-only mode
    cfg_l = 1; lv = 1; ls = 0;
    push_inl(11'h020, 1, "R5"); push_inl(11'h021, 0, "R5");
    for (int c = 0; c < 6; c++) tick("R5");
    ls = 1;
    for (int c = 0; c < 4; c++) tick("R5");
    drain("R5");

    // R6: stores block too when both kinds contend
    cfg_l = 0; lv = 1; ls = 1;
    push_inl(11'h030, 0, "R6");
    for (int c = 0; c < 8; c++) tick("R6");
    drain("R6");

    // R7: hint overtakes queued inline requests, stays behind earlier hint
    cfg_l = 1; lv = 1; ls = 0;
    push_inl(11'h040, 0, "R7"); push_inl(11'h041, 1, "R7");
    hv = 1; hl = 11'h140; tick("R7");
    hl = 11'h141; tick("R7"); hv = 0;
    drain("R7");

    // R8: simultaneous hint and inline with a single free slot
    lv = 1; ls = 0;
    push_inl(11'h050, 0, "R8"); push_inl(11'h051, 1, "R8"); push_inl(11'h052, 0, "R8");
    hv = 1; hl = 11'h150; iv = 1; il = 11'h053; isel = 1; tick("R8");
    quiet(); tick("R8");
    drain("R8");

    // R9: trigger marks queued inline, fresh arrival unmarked, stale still served
    lv = 1; ls = 0;
    push_inl(11'h060, 0, "R9");
    hv = 1; hl = 11'h160; tick("R9"); hv = 0;
    trg = 1; iv = 1; il = 11'h061; isel = 1; tick("R9"); quiet();
    drain("R9");

    // R10: purge removes stale and keeps order of survivors
    lv = 1; ls = 0;
    push_inl(11'h070, 0, "R10"); push_inl(11'h071, 1, "R10");
    trg = 1; iv = 1; il = 11'h072; isel = 0; tick("R10"); quiet();
    push_inl(11'h073, 1, "R10");
    prg = 1; tick("R10"); prg = 0;
    drain("R10");

    // R11: full queue drops and flags overflow
    lv = 1; ls = 0;
    for (int i = 0; i < 4; i++) push_inl(LW'(11'h080 + i), 1'(i), "R11");
    push_inl(11'h0FF, 0, "R11");
    tick("R11");
    drain("R11");

    // R12: stale head enters the pipe in the purge cycle
    lv = 1; ls = 0;
    push_inl(11'h090, 0, "R12"); push_inl(11'h091, 1, "R12");
    trg = 1; tick("R12"); trg = 0;
    lv = 0; prg = 1; tick("R12"); prg = 0;
    drain("R12");

    // Random phases in both conflict modes
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 2; ph++) begin
      cfg_l = 1'(ph);
      for (int c = 0; c < 2500; c++) begin
        iv   = ($urandom % 100) < 45;
        il   = LW'($urandom);
        isel = 1'($urandom);
        hv   = ($urandom % 100) < 10;
        hl   = LW'($urandom);
        trg  = ($urandom % 100) < 6;
        prg  = ($urandom % 100) < 6;
        lv   = ($urandom % 100) < 40;
        ls   = 1'($urandom);
        tick("R2");
      end
      drain("R9");
    end

    report();
  end

endmodule